// File: doc/BRIEF.md
# Time-Stamp Grouped Destination Selector

This block picks, for every outgoing level-1 feature message, the destination port it is sent to, using only the message's time stamp. Consecutive time stamps are grouped into blocks of `GROUP_N`. Every stamp in one block goes to the same port, and successive blocks step through the `NUM_PORTS` ports in turn, so each port sees a whole run of stamps and the load rotates every `GROUP_N` stamp periods.

A destination that looks at a sliding window of three stamps needs the two stamps just before its own block. The last two stamps of each block, at offsets `GROUP_N-2` and `GROUP_N-1`, are therefore flagged for an extra copy to the next port, which already owns the following block. The selector raises a copy-valid and gives the copy's port index beside the primary index. Results are registered with one cycle of latency, and a new message may be offered on every cycle.

Stamps are assumed to arrive in time order. A stamp numerically lower than the previous accepted one is taken as a wrap of the stamp counter, and the mapping carries on as if the stamp had one more high-order bit. Grouping is thus unbroken across the wrap even when `2^TS_W` is not a multiple of `GROUP_N*NUM_PORTS`.

Top module: `ts_dest_sel`

## Requirements
- R1: While `rst_ni` is low, `valid_o` and `copy_valid_o` are 0. The wrap history is cleared, so the first stamp after reset maps with no wrap offset.
- R2: For an accepted stamp with extended value E (the stamp plus 2^TS_W for each wrap seen since reset), `port_o` equals floor(E / GROUP_N) mod NUM_PORTS, with `valid_o` high, one cycle after `valid_i` was high.
- R3: Stamps E and E+1 that share floor(E / GROUP_N) map to the same port. When E+1 opens a new block, the port increases by exactly 1 modulo NUM_PORTS.
- R4: `copy_valid_o` is 1 exactly when E mod GROUP_N is GROUP_N-2 or GROUP_N-1. `copy_port_o` is then (port_o + 1) mod NUM_PORTS. `copy_valid_o` is never 1 while `valid_o` is 0.
- R5: A message is accepted on every cycle in which `valid_i` is high, with no gap needed between messages.
- R6: An accepted stamp lower than the previous accepted stamp counts as one wrap, adding 2^TS_W to E. The block spanning the wrap keeps a single port.
- R7: A cycle with `valid_i` low gives `valid_o` and `copy_valid_o` low on the next cycle. The stamp presented in that cycle does not count as a wrap.
- R8: A repeated stamp, equal to the previous accepted one, maps to the same port and is not a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Message present this cycle |
| ts_i | input | TS_W | Time stamp of the message |
| valid_o | output | 1 | Registered result valid |
| port_o | output | PORT_W | Primary destination port |
| copy_valid_o | output | 1 | A copy also goes to `copy_port_o` |
| copy_port_o | output | PORT_W | Port receiving the boundary copy |

## Verification
A hand-computed vector table covers stamps at the first, middle and last offsets of blocks, at rotation from the last port back to port 0, a repeated stamp, and a wrap from the top stamp value to small values. It separates a correct block mapping from one that is off by one offset or one port. A long run of consecutive stamps, starting mid-range with repeats mixed in, crosses several wraps with a residue that is not zero. Only correct wrap accounting keeps the port sequence continuous there. Directed cases insert an idle cycle carrying a lower stamp, and a mid-run reset, to show that neither a discarded stamp nor history from before the reset shifts later mappings.

// File: rtl/ts_sel_pkg.sv
package ts_sel_pkg;
  localparam int unsigned MIN_GROUP_N = 3;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ts_wrap_tracker.sv
// Keeps (wraps * 2^TS_W) mod (N*P) as a running residue.
module ts_wrap_tracker
  import ts_sel_pkg::*;
#(
  parameter int unsigned TS_W      = 8,
  parameter int unsigned GROUP_N   = 5,
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned SPAN_NP  = GROUP_N * NUM_PORTS,
  localparam int unsigned RES_W    = idx_w(SPAN_NP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [TS_W-1:0]  ts_i,
  output logic [RES_W-1:0] base_o
);
  localparam longint unsigned TS_SPAN = 64'd1 << TS_W;
  localparam int unsigned     WRAP_K  = int'(TS_SPAN % SPAN_NP);
  localparam logic [RES_W:0]  NP_L    = (RES_W+1)'(SPAN_NP);
  localparam logic [RES_W:0]  K_L     = (RES_W+1)'(WRAP_K);

  logic [RES_W-1:0] base_q;
  logic [TS_W-1:0]  prev_q;
  logic             seen_q;
  logic             wrap;
  logic [RES_W:0]   bsum;
  logic [RES_W:0]   badv;

  always_comb begin
    wrap   = valid_i && seen_q && (ts_i < prev_q);
    bsum   = {1'b0, base_q} + K_L;
    badv   = (bsum >= NP_L) ? (bsum - NP_L) : bsum;
    base_o = wrap ? RES_W'(badv) : base_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      prev_q <= '0;
      seen_q <= 1'b0;
    end else if (valid_i) begin
      base_q <= base_o;
      prev_q <= ts_i;
      seen_q <= 1'b1;
    end
  end

  assert_base_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, base_q} < NP_L);

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(base_q));

  assert_repeat_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && seen_q && ts_i == prev_q) |=> $stable(base_q));
endmodule

// File: rtl/ts_group_mapper.sv
// Residue r = (base + ts) mod N*P; port = r / N, offset = r mod N.
module ts_group_mapper
  import ts_sel_pkg::*;
#(
  parameter int unsigned TS_W      = 8,
  parameter int unsigned GROUP_N   = 5,
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned SPAN_NP  = GROUP_N * NUM_PORTS,
  localparam int unsigned RES_W    = idx_w(SPAN_NP),
  localparam int unsigned PORT_W   = idx_w(NUM_PORTS)
) (
  input  logic [RES_W-1:0]  base_i,
  input  logic [TS_W-1:0]   ts_i,
  output logic [PORT_W-1:0] port_o,
  output logic              copy_o,
  output logic [PORT_W-1:0] copy_port_o
);
  localparam logic [RES_W:0]    NP_L    = (RES_W+1)'(SPAN_NP);
  localparam logic [RES_W:0]    N_L     = (RES_W+1)'(GROUP_N);
  localparam logic [RES_W:0]    EDGE_L  = (RES_W+1)'(GROUP_N - 2);
  localparam logic [PORT_W-1:0] LAST_P  = PORT_W'(NUM_PORTS - 1);

  logic [RES_W-1:0] ts_res;
  logic [RES_W:0]   sum;
  logic [RES_W:0]   res;
  logic [RES_W:0]   off;

  always_comb begin
    ts_res = RES_W'(32'(ts_i) % SPAN_NP);
    sum    = {1'b0, base_i} + {1'b0, ts_res};
    res    = (sum >= NP_L) ? (sum - NP_L) : sum;
    off    = res % N_L;
    port_o = PORT_W'(res / N_L);
    copy_o = (off >= EDGE_L);
    copy_port_o = (port_o == LAST_P) ? '0 : port_o + 1'b1;
  end
endmodule

// File: rtl/ts_dest_sel.sv
module ts_dest_sel
  import ts_sel_pkg::*;
#(
  parameter int unsigned TS_W      = 8,
  parameter int unsigned GROUP_N   = 5,
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned SPAN_NP  = GROUP_N * NUM_PORTS,
  localparam int unsigned RES_W    = idx_w(SPAN_NP),
  localparam int unsigned PORT_W   = idx_w(NUM_PORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [TS_W-1:0]   ts_i,
  output logic              valid_o,
  output logic [PORT_W-1:0] port_o,
  output logic              copy_valid_o,
  output logic [PORT_W-1:0] copy_port_o
);
  logic [RES_W-1:0]  base;
  logic [PORT_W-1:0] map_port;
  logic [PORT_W-1:0] map_copy_port;
  logic              map_copy;

  ts_wrap_tracker #(
    .TS_W(TS_W), .GROUP_N(GROUP_N), .NUM_PORTS(NUM_PORTS)
  ) u_wrap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .ts_i   (ts_i),
    .base_o (base)
  );

  ts_group_mapper #(
    .TS_W(TS_W), .GROUP_N(GROUP_N), .NUM_PORTS(NUM_PORTS)
  ) u_map (
    .base_i     (base),
    .ts_i       (ts_i),
    .port_o     (map_port),
    .copy_o     (map_copy),
    .copy_port_o(map_copy_port)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      port_o       <= '0;
      copy_valid_o <= 1'b0;
      copy_port_o  <= '0;
    end else begin
      valid_o      <= valid_i;
      copy_valid_o <= valid_i && map_copy;
      if (valid_i) begin
        port_o      <= map_port;
        copy_port_o <= map_copy_port;
      end
    end
  end

  assert_accept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !copy_valid_o));

  assert_copy_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_valid_o |-> valid_o);

  assert_port_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (32'(port_o) < NUM_PORTS));

  assert_same_stamp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && valid_o && ts_i == $past(ts_i)) |=> (port_o == $past(port_o)));

  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && valid_o && ts_i == TS_W'($past(ts_i) + 1'b1)) |=>
      ((port_o == $past(port_o)) ||
       (32'(port_o) == (32'($past(port_o)) + 1) % NUM_PORTS)));
endmodule

// File: tb/ts_dest_sel_tb.sv
module ts_dest_sel_tb;
  localparam int unsigned TS_W = 8;
  localparam int unsigned GN   = 5;
  localparam int unsigned NP   = 4;
  localparam int unsigned PW   = 2;
  localparam int NVEC = 15;

  // columns: stamp, primary port, copy flag, copy port
  localparam int VEC_TS [NVEC] = '{0,3,4,5,8,19,20,42,43,99,99,255,0,3,4};
  localparam int VEC_P  [NVEC] = '{0,0,0,1,1,3,0,0,0,3,3,3,3,3,0};
  localparam int VEC_CV [NVEC] = '{0,1,1,0,1,1,0,0,1,1,1,0,0,1,0};
  localparam int VEC_CP [NVEC] = '{1,1,1,2,2,0,1,1,1,0,0,0,0,0,1};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [TS_W-1:0] ts_i = '0;
  logic valid_o, copy_valid_o;
  logic [PW-1:0] port_o, copy_port_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state
  bit m_seen = 1'b0;
  int m_prev = 0;
  int m_epoch = 0;
  bit pend = 1'b0;
  string pend_req;
  int e_v, e_p, e_cv, e_cp;

  always #10 clk = ~clk;

  ts_dest_sel #(.TS_W(TS_W), .GROUP_N(GN), .NUM_PORTS(NP)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .ts_i(ts_i),
    .valid_o(valid_o), .port_o(port_o),
    .copy_valid_o(copy_valid_o), .copy_port_o(copy_port_o)
  );

  task automatic check_pending();
    bit bad;
    if (!pend) return;
    n_run++;
    bad = (int'(valid_o) != e_v) || (int'(copy_valid_o) != e_cv);
    if (e_v != 0 && int'(port_o) != e_p) bad = 1'b1;
    if (e_cv != 0 && int'(copy_port_o) != e_cp) bad = 1'b1;
    if (bad) begin
      n_fail++;
      $display("FAIL %s: got v=%0d p=%0d cv=%0d cp=%0d exp v=%0d p=%0d cv=%0d cp=%0d",
               pend_req, valid_o, port_o, copy_valid_o, copy_port_o, e_v, e_p, e_cv, e_cp);
    end
    pend = 1'b0;
  endtask

  // tab_p < 0 means use the reference model for the expectation
  task automatic step(input bit v, input int ts, input string req,
                      input int tab_p = -1, input int tab_cv = 0, input int tab_cp = 0);
    int e;
    @(negedge clk);
    check_pending();
    valid_i = v;
    ts_i = TS_W'(ts);
    if (v) begin
      if (m_seen && ts < m_prev) m_epoch++;
      m_prev = ts;
      m_seen = 1'b1;
      e = m_epoch * (1 << TS_W) + ts;
      e_v = 1;
      e_p = (e / GN) % NP;
      e_cv = ((e % GN) >= GN - 2) ? 1 : 0;
      e_cp = (e_p + 1) % NP;
      if (tab_p >= 0) begin
        e_p = tab_p; e_cv = tab_cv; e_cp = tab_cp;
      end
    end else begin
      e_v = 0; e_cv = 0; e_p = 0; e_cp = 0;
    end
    pend = 1'b1;
    pend_req = req;
  endtask

  task automatic flush();
    @(negedge clk);
    check_pending();
    valid_i = 1'b0;
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    pend = 1'b0;
    #1;
    n_run++;
    if (valid_o !== 1'b0 || copy_valid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: got v=%0d cv=%0d exp v=0 cv=0", req, valid_o, copy_valid_o);
    end
    m_seen = 1'b0; m_epoch = 0; m_prev = 0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset("R1 initial reset");

    // R2 R3 R4 R5 R6 R8: vector table, one message per cycle
    for (int i = 0; i < NVEC; i++)
      step(1'b1, VEC_TS[i], "R2/R4 table", VEC_P[i], VEC_CV[i], VEC_CP[i]);
    flush();

    // R1: mid-run reset clears wrap history; 10 -> block 2, port 2
    do_reset("R1 mid-run reset");
    step(1'b1, 10, "R1 post-reset map", 2, 0, 3);
    flush();

    // R3 R6 R8: long run from mid-range across several wraps
    do_reset("R1 before ramp");
    begin
      int t = 137;
      for (int k = 0; k < 900; k++) begin
        step(1'b1, t, "R3/R6 ramp");
        if (k % 37 == 0) step(1'b1, t, "R8 repeat in ramp");
        t = (t + 1) % (1 << TS_W);
      end
    end
    flush();

    // R7: idle cycle with a lower stamp must not count as a wrap
    step(1'b1, 200, "R7 before idle");
    step(1'b0, 3, "R7 idle output");
    step(1'b1, 201, "R7 after idle");
    flush();

    // R5/R4: alternating gaps and bursts
    step(1'b1, 202, "R5 burst");
    step(1'b1, 203, "R4 edge");
    step(1'b0, 0, "R7 gap");
    step(1'b1, 204, "R4 edge");
    step(1'b1, 205, "R3 boundary");
    flush();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule